// File: doc/BRIEF.md
# Delimited Serial Packet Receiver

This block takes a synchronous bit-serial link driven by a remote sender and turns it into a stream of octets with packet framing. The sender supplies a bit clock, a serial data line, a framing line that stays high for the length of a message, and an abort line. The receiver sends two flow-control signals back. One reports whether it can take the next octet. The other reports whether it can take a whole new packet.

All link inputs pass through a two-stage synchroniser into the system clock domain. Bits are captured on the rising edge of the link clock, most significant bit first. Each completed octet is held back by one octet, so that the last octet of a message can be marked as the end of the packet when the framing line falls. Octets leave through a one-entry holding register on a valid/ready byte port. Each octet carries three flags: start of packet, end of packet and error.

Top module: `serial_pkt_rx`

## Requirements
- R1: Bits are taken only on a rising edge of `lnkClk` while `lnkFrame` is high, and the first bit taken is bit 7 (MSB) of the octet. Once `outValid` is high, it falls only in a cycle that follows one in which `outReady` was high.
- R2: Each byte is presented as {outErr, outEop, outSop, outData}. The first complete octet of a message has `outSop`=1, and the last complete octet before `lnkFrame` falls has `outEop`=1; a one-octet message has both set. In a message with no abort and no overrun, every `outErr` is 0.
- R3: Bits left over after the last whole octet of a message are discarded. A message with fewer than 8 bits produces no byte.
- R4: When `lnkAbort` is high during a message, the partial octet and the octet held back are discarded. If at least one byte of that message has already been presented, exactly one marker follows: data 0x00 with `outSop`=0, `outEop`=1, `outErr`=1. Otherwise nothing is presented. The link is then ignored until `lnkFrame` is low.
- R5: `lnkBusy` is high exactly when `outValid` is high and `outReady` is low.
- R6: Suppose an octet completes while an earlier octet is waiting and the holding register is full and not being accepted. The earlier octet is then lost, and the final byte of that message has `outErr`=1 (and `outSop`=0).
- R7: `lnkReady` is high only when the receiver is idle, `outValid` is low and `outReady` is high. It stays low from the start of a message until the message has been fully handled.
- R8: While `outValid` is high and `outReady` is low, `outData`, `outSop`, `outEop` and `outErr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lnkClk | input | 1 | Link bit clock from the sender |
| lnkData | input | 1 | Link serial data, MSB first |
| lnkFrame | input | 1 | High for the span of a message |
| lnkAbort | input | 1 | High to abandon the current message |
| lnkBusy | output | 1 | Next octet cannot be accepted |
| lnkReady | output | 1 | A new packet can be accepted |
| outValid | output | 1 | Byte on the output port is valid |
| outReady | input | 1 | Consumer accepts the byte |
| outData | output | OCTET_W | Received octet |
| outSop | output | 1 | First octet of a packet |
| outEop | output | 1 | Last octet of a packet |
| outErr | output | 1 | Packet ended in overrun or abort |

## Verification
The checks assume a few things about the link. The link clock runs no faster than a quarter of the system clock. Data, framing and abort are stable around each rising link-clock edge. The framing line never changes within a few system cycles of a link-clock edge. Under these conditions every bit reaches the receiver as exactly one edge event, with data of the same age. The stimulus meets these conditions by design. It uses a link-clock period of eight system cycles, changes data half a link period before each rising edge, drops the framing line half a period after the last falling edge, and raises abort only between link-clock pulses.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_FLUSH, ST_HOLD} srxState_e;

  typedef struct packed {
    logic startPkt;
    logic takeBit;
    logic dropPkt;
    logic pushLast;
    logic pushMarker;
  } srxCmd_t;

  typedef struct packed {
    logic bitEdge;
    logic frame;
    logic abort;
    logic pendValid;
    logic holdFree;
    logic sentAny;
  } srxStat_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  srxStat_t stat,
  output srxCmd_t  cmd,
  output logic     isIdle
);
  srxState_e state, stateNxt;
  logic markMode, markModeNxt;

  always_comb begin
    cmd = '0;
    stateNxt = state;
    markModeNxt = markMode;
    case (state)
      ST_IDLE: begin
        if (stat.frame && !stat.abort) begin
          cmd.startPkt = 1'b1;
          stateNxt = ST_RECV;
        end
      end
      ST_RECV: begin
        if (stat.abort) begin
          cmd.dropPkt = 1'b1;
          markModeNxt = stat.sentAny;
          stateNxt = stat.sentAny ? ST_FLUSH : ST_HOLD;
        end else if (!stat.frame) begin
          markModeNxt = 1'b0;
          stateNxt = ST_FLUSH;
        end else if (stat.bitEdge) begin
          cmd.takeBit = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (markMode) begin
          if (stat.holdFree) begin
            cmd.pushMarker = 1'b1;
            stateNxt = ST_HOLD;
          end
        end else if (!stat.pendValid) begin
          stateNxt = ST_HOLD;
        end else if (stat.holdFree) begin
          cmd.pushLast = 1'b1;
          stateNxt = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!stat.frame) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      markMode <= 1'b0;
    end else begin
      state <= stateNxt;
      markMode <= markModeNxt;
    end
  end

  assign isIdle = (state == ST_IDLE);
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int OCTET_W = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lnkClk,
  input  logic               lnkData,
  input  logic               lnkFrame,
  input  logic               lnkAbort,
  input  srxCmd_t            cmd,
  output srxStat_t           stat,
  input  logic               outReady,
  output logic               outValid,
  output logic [OCTET_W-1:0] outData,
  output logic               outSop,
  output logic               outEop,
  output logic               outErr
);
  localparam int CNT_W = (OCTET_W > 1) ? $clog2(OCTET_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OCTET_W - 1);

  // synchronisers; clock pipe has one extra stage for edge detection
  logic [SYNC_N:0]   clkPipe;
  logic [SYNC_N-1:0] datPipe, frmPipe, abtPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      datPipe <= '0;
      frmPipe <= '0;
      abtPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[SYNC_N-1:0], lnkClk};
      datPipe <= {datPipe[SYNC_N-2:0], lnkData};
      frmPipe <= {frmPipe[SYNC_N-2:0], lnkFrame};
      abtPipe <= {abtPipe[SYNC_N-2:0], lnkAbort};
    end
  end

  logic [OCTET_W-1:0] shiftReg, pendData, nextShift;
  logic [CNT_W-1:0]   bitCnt;
  logic pendValid, pendSop, firstOct, errSticky, sentAny;
  logic holdFree, octetDone;

  assign holdFree  = !outValid || outReady;
  assign nextShift = {shiftReg[OCTET_W-2:0], datPipe[SYNC_N-1]};
  assign octetDone = cmd.takeBit && (bitCnt == LAST_BIT);

  always_comb begin
    stat.bitEdge   = clkPipe[SYNC_N-1] & ~clkPipe[SYNC_N];
    stat.frame     = frmPipe[SYNC_N-1];
    stat.abort     = abtPipe[SYNC_N-1];
    stat.pendValid = pendValid;
    stat.holdFree  = holdFree;
    stat.sentAny   = sentAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      pendData  <= '0;
      bitCnt    <= '0;
      pendValid <= 1'b0;
      pendSop   <= 1'b0;
      firstOct  <= 1'b0;
      errSticky <= 1'b0;
      sentAny   <= 1'b0;
      outValid  <= 1'b0;
      outData   <= '0;
      outSop    <= 1'b0;
      outEop    <= 1'b0;
      outErr    <= 1'b0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (cmd.startPkt) begin
        bitCnt    <= '0;
        pendValid <= 1'b0;
        firstOct  <= 1'b1;
        errSticky <= 1'b0;
        sentAny   <= 1'b0;
      end
      if (cmd.dropPkt) begin
        bitCnt    <= '0;
        pendValid <= 1'b0;
      end
      if (cmd.takeBit) begin
        shiftReg <= nextShift;
        bitCnt   <= bitCnt + 1'b1;
        if (octetDone) begin
          bitCnt <= '0;
          if (pendValid) begin
            if (holdFree) begin
              outValid <= 1'b1;
              outData  <= pendData;
              outSop   <= pendSop;
              outEop   <= 1'b0;
              outErr   <= 1'b0;
              sentAny  <= 1'b1;
            end else begin
              errSticky <= 1'b1;
            end
          end
          pendData  <= nextShift;
          pendSop   <= firstOct;
          firstOct  <= 1'b0;
          pendValid <= 1'b1;
        end
      end
      if (cmd.pushLast) begin
        outValid  <= 1'b1;
        outData   <= pendData;
        outSop    <= pendSop;
        outEop    <= 1'b1;
        outErr    <= errSticky;
        pendValid <= 1'b0;
      end
      if (cmd.pushMarker) begin
        outValid <= 1'b1;
        outData  <= '0;
        outSop   <= 1'b0;
        outEop   <= 1'b1;
        outErr   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_pkt_rx.sv
module serial_pkt_rx
  import srx_pkg::*;
#(
  parameter int OCTET_W = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lnkClk,
  input  logic               lnkData,
  input  logic               lnkFrame,
  input  logic               lnkAbort,
  output logic               lnkBusy,
  output logic               lnkReady,
  output logic               outValid,
  input  logic               outReady,
  output logic [OCTET_W-1:0] outData,
  output logic               outSop,
  output logic               outEop,
  output logic               outErr
);
  srxCmd_t  cmd;
  srxStat_t stat;
  logic     isIdle;

  srx_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .cmd    (cmd),
    .isIdle (isIdle)
  );

  srx_datapath #(.OCTET_W(OCTET_W), .SYNC_N(SYNC_N)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .lnkClk   (lnkClk),
    .lnkData  (lnkData),
    .lnkFrame (lnkFrame),
    .lnkAbort (lnkAbort),
    .cmd      (cmd),
    .stat     (stat),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData),
    .outSop   (outSop),
    .outEop   (outEop),
    .outErr   (outErr)
  );

  assign lnkBusy  = outValid & ~outReady;
  assign lnkReady = isIdle & ~outValid & outReady;
endmodule

// File: rtl/serial_pkt_rx_chk.sv
module serial_pkt_rx_chk #(
  parameter int OCTET_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               lnkBusy,
  input logic               lnkReady,
  input logic               outValid,
  input logic               outReady,
  input logic [OCTET_W-1:0] outData,
  input logic               outSop,
  input logic               outEop,
  input logic               outErr
);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop)
                              && $stable(outEop) && $stable(outErr));

  a_r6_err_on_end_only: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outEop && !outSop);

  a_r5_busy_needs_byte: assert property (@(posedge clk) disable iff (!rstN)
    lnkBusy |-> outValid);

  a_r7_ready_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    lnkReady |-> !outValid && outReady);

  a_r1_leave_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady));
endmodule

bind serial_pkt_rx serial_pkt_rx_chk #(.OCTET_W(OCTET_W)) chk_i (.*);

// File: tb/serial_pkt_rx_tb_top.sv
`timescale 1ns/1ps
module serial_pkt_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lnkClk = 1'b0, lnkData = 1'b0, lnkFrame = 1'b0, lnkAbort = 1'b0;
  logic lnkBusy, lnkReady, outValid, outSop, outEop, outErr;
  logic outReady = 1'b0;
  logic [7:0] outData;

  int checks = 0;
  int fails = 0;
  int bpMode = 0;
  logic [10:0] expQ[$];

  always #5 clk = ~clk;

  serial_pkt_rx dut_i (
    .clk(clk), .rstN(rstN), .lnkClk(lnkClk), .lnkData(lnkData),
    .lnkFrame(lnkFrame), .lnkAbort(lnkAbort), .lnkBusy(lnkBusy),
    .lnkReady(lnkReady), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSop(outSop), .outEop(outEop), .outErr(outErr)
  );

  // {nBits, seed, abortAt (255 = none), bpMode}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {8'd24, 8'hA5, 8'd255, 2'd0},
    {8'd8,  8'h3C, 8'd255, 2'd1},
    {8'd13, 8'h81, 8'd255, 2'd2},
    {8'd5,  8'h7E, 8'd255, 2'd0},
    {8'd40, 8'h10, 8'd255, 2'd1},
    {8'd30, 8'hC3, 8'd255, 2'd0},
    {8'd27, 8'h55, 8'd20,  2'd1},
    {8'd20, 8'h99, 8'd11,  2'd0},
    {8'd32, 8'h01, 8'd3,   2'd2}
  };

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byteVal(input logic [7:0] seed, input int i);
    return (seed + 8'(i * 59)) ^ 8'(i);
  endfunction

  // consumer back-pressure
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      case (bpMode)
        0: outReady = 1'b1;
        1: outReady = ~outReady;
        2: outReady = (cyc % 4 == 0);
        default: outReady = 1'b0;
      endcase
    end
  end

  // byte monitor against reference queue
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3/R4 unexpected byte", {5'd0, outErr, outEop, outSop, outData}, 16'h0);
        end else begin
          logic [10:0] e;
          e = expQ.pop_front();
          check({outErr, outEop, outSop, outData} == e,
                e[10] ? "R4/R6 error byte" : "R1/R2 byte",
                {5'd0, outErr, outEop, outSop, outData}, {5'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic expectPkt(input int nBits, input logic [7:0] seed, input int abortAt);
    int full;
    if (abortAt < nBits) begin
      full = abortAt / 8;
      for (int i = 0; i < full - 1; i++) expQ.push_back({1'b0, 1'b0, i == 0, byteVal(seed, i)});
      if (full >= 2) expQ.push_back({1'b1, 1'b1, 1'b0, 8'h00});
    end else begin
      full = nBits / 8;
      for (int i = 0; i < full; i++) expQ.push_back({1'b0, i == full - 1, i == 0, byteVal(seed, i)});
    end
  endtask

  task automatic sendPkt(input int nBits, input logic [7:0] seed, input int abortAt);
    lnkFrame = 1'b1;
    #50;
    for (int i = 0; i < nBits; i++) begin
      if (i == abortAt) break;
      lnkData = byteVal(seed, i / 8) >> (7 - (i % 8));
      #40 lnkClk = 1'b1;
      #40 lnkClk = 1'b0;
    end
    if (abortAt < nBits) begin
      #40 lnkAbort = 1'b1;
      #200 lnkFrame = 1'b0;
      #100 lnkAbort = 1'b0;
    end else begin
      #40 lnkFrame = 1'b0;
    end
    #100;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 600 && expQ.size() != 0; i++) @(posedge clk);
    repeat (20) @(posedge clk);
    #3;
    check(expQ.size() == 0, tag, 16'(expQ.size()), 16'h0);
  endtask

  initial begin
    logic [7:0] held;
    bpMode = 0;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    check(outValid == 1'b0, "R1 reset valid", 16'(outValid), 16'h0);
    check(lnkBusy == 1'b0, "R5 reset busy", 16'(lnkBusy), 16'h0);
    check(lnkReady == 1'b1, "R7 reset ready", 16'(lnkReady), 16'h1);

    for (int v = 0; v < NV; v++) begin
      bpMode = int'(VEC[v][1:0]);
      expectPkt(int'(VEC[v][25:18]), VEC[v][17:10], int'(VEC[v][9:2]));
      sendPkt(int'(VEC[v][25:18]), VEC[v][17:10], int'(VEC[v][9:2]));
      drain("R2/R3/R4 queue drained");
    end

    // R7: ready low during a message
    bpMode = 0;
    expectPkt(16, 8'h6D, 255);
    fork
      sendPkt(16, 8'h6D, 255);
      begin #300; check(lnkReady == 1'b0, "R7 ready low in message", 16'(lnkReady), 16'h0); end
    join
    drain("R7 queue drained");

    // R7: idle but consumer stalled
    bpMode = 3;
    repeat (5) @(posedge clk);
    #3;
    check(lnkReady == 1'b0, "R7 ready needs consumer", 16'(lnkReady), 16'h0);
    check(lnkBusy == 1'b0, "R5 busy low when empty", 16'(lnkBusy), 16'h0);

    // R6 overrun with consumer stalled; R5 busy; R8 hold
    expQ.push_back({1'b0, 1'b0, 1'b1, byteVal(8'h2B, 0)});
    expQ.push_back({1'b1, 1'b1, 1'b0, byteVal(8'h2B, 2)});
    sendPkt(24, 8'h2B, 255);
    repeat (10) @(posedge clk);
    #3;
    check(lnkBusy == 1'b1, "R5 busy when stalled", 16'(lnkBusy), 16'h1);
    check(lnkReady == 1'b0, "R7 ready low when full", 16'(lnkReady), 16'h0);
    held = outData;
    repeat (20) @(posedge clk);
    #3;
    check(outValid && outData == held, "R8 byte held", {7'd0, outValid, outData}, {8'h01, held});
    bpMode = 0;
    drain("R6 queue drained");
    check(lnkBusy == 1'b0, "R5 busy released", 16'(lnkBusy), 16'h0);
    check(lnkReady == 1'b1, "R7 ready back", 16'(lnkReady), 16'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule